// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns their full signed product of `2*WIDTH` bits. It works serially: one Booth recoding step per clock. A start request copies the multiplicand into an internal register and the multiplier into the low product register. It also clears the high accumulator and the extra history bit below the multiplier.

Each step looks at the lowest multiplier bit together with the bit that was shifted out before it. A run of 1s in the multiplier costs one subtraction where the run begins and one addition where it ends. Bits inside a run, and runs of 0s, cost nothing. After the add, subtract or no-op, the accumulator, multiplier and history bit are shifted right together as one signed quantity, so the sign is copied into the top bit. After `WIDTH` steps the high half of the product is in the accumulator and the low half is in the multiplier register.

The surrounding logic raises `start` for one cycle with the operands valid. It then waits for the one-cycle `done` pulse and reads `prod_hi` and `prod_lo`. These stay valid until the next accepted start.

Top module: `booth_seq_mul`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `prod_hi` and `prod_lo` are all 0.
- R2: When `done` is high, `{prod_hi, prod_lo}` is the signed product of the `mcand` and `mplier` values captured at the accepted start, as a `2*WIDTH`-bit two's-complement number, for any pair of operands.
- R3: `done` is high for exactly one cycle. It rises on the clock edge that comes `WIDTH` edges after the edge that accepted the start.
- R4: `busy` is high from the edge after an accepted start through the last recoding step, which is `WIDTH` cycles. It is low in the cycle where `done` is high.
- R5: A start is accepted only when `busy` is low. While `busy` is high, `start` and any change on `mcand` or `mplier` have no effect on the result or on the timing.
- R6: When `busy` is low, the product outputs hold their value until the next accepted start. A start raised in the same cycle as `done` is accepted at once.
- R7: Extreme operands give exact results. The most negative value times itself gives 2^(2*WIDTH-2). The most negative value times -1 gives 2^(WIDTH-1). Any value times 0, and 0 times any value, gives 0.
- R8: The recoding works on the pair (current multiplier bit, previous bit), where the previous bit is 0 for the first step. Pair 10 subtracts the multiplicand, pair 01 adds it, and pairs 00 and 11 leave the accumulator unchanged. A multiplier of alternating bits, such as 0x55 at WIDTH=8, therefore needs an operation on every step and must still give the correct product.
- R9: With WIDTH=8, the product of 22 and -34 reads back as -748 (0xFD14).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse: the product is ready |
| prod_hi | output | WIDTH | Upper half of the signed product |
| prod_lo | output | WIDTH | Lower half of the signed product |

## Verification
The hardest case to reach is the one where the accumulator would overflow its `WIDTH` bits in the middle of a step. This happens when the multiplicand is the most negative value and the first recoding pair subtracts it. The stimulus reaches it directly: it runs the most negative multiplicand against multipliers of -1, of itself, and of alternating bit patterns. It also drives inputs that must have no effect: starts and new operands while `busy` is high, and a start held high through `done`.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } booth_state_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic      cur_bit,
  input  logic      prev_bit,
  output booth_op_e op
);

  // Pair (current, previous): 10 starts a run of 1s, 01 closes it.
  always_comb begin
    unique case ({cur_bit, prev_bit})
      2'b10:   op = OP_SUB;
      2'b01:   op = OP_ADD;
      default: op = OP_NONE;
    endcase
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int AW   = WIDTH + 1
) (
  input  logic [AW-1:0]    acc,
  input  logic [WIDTH-1:0] m,
  input  booth_op_e        op,
  output logic [AW-1:0]    res
);

  logic [AW-1:0] m_ext;
  logic [AW-1:0] operand;
  logic          cin;

  // The multiplicand is sign-extended by one guard bit. A subtraction adds
  // the inverted operand with a carry in.
  assign m_ext = {m[WIDTH-1], m};

  always_comb begin
    operand = '0;
    cin     = 1'b0;
    case (op)
      OP_ADD: begin operand = m_ext;  cin = 1'b0; end
      OP_SUB: begin operand = ~m_ext; cin = 1'b1; end
      default: begin operand = '0; cin = 1'b0; end
    endcase
  end

  assign res = acc + operand + AW'(cin);

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int CW   = $clog2(WIDTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);

  booth_state_e  state_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign load = (state_q == ST_IDLE) && start;
  assign step = (state_q == ST_RUN);
  assign busy = (state_q == ST_RUN);
  assign last = (cnt_q == CW'(WIDTH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                       // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);                                                       // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_q < CW'(WIDTH)));                                        // R3
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);                                            // R5

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
  import booth_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int AW   = WIDTH + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] mcand,
  input  logic [WIDTH-1:0] mplier,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] prod_hi,
  output logic [WIDTH-1:0] prod_lo
);

  logic             load;
  logic             step;
  logic [AW-1:0]    acc_q;
  logic [WIDTH-1:0] mq_q;
  logic             hist_q;
  logic [WIDTH-1:0] m_q;
  booth_op_e        op;
  logic [AW-1:0]    sum;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  booth_recoder u_rec (
    .cur_bit  (mq_q[0]),
    .prev_bit (hist_q),
    .op       (op)
  );

  booth_addsub #(.WIDTH(WIDTH)) u_alu (
    .acc (acc_q),
    .m   (m_q),
    .op  (op),
    .res (sum)
  );

  // The accumulator has one guard bit, so A - M with the most negative M
  // keeps its true sign through the arithmetic shift.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      mq_q   <= '0;
      hist_q <= 1'b0;
      m_q    <= '0;
    end else if (load) begin
      acc_q  <= '0;
      mq_q   <= mplier;
      hist_q <= 1'b0;
      m_q    <= mcand;
    end else if (step) begin
      acc_q  <= {sum[AW-1], sum[AW-1:1]};
      mq_q   <= {sum[0], mq_q[WIDTH-1:1]};
      hist_q <= mq_q[0];
    end
  end

  assign prod_hi = acc_q[WIDTH-1:0];
  assign prod_lo = mq_q;

  AST_MCAND_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(m_q));                                     // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo)));         // R6
  AST_SHIFT_HIST: assert property (@(posedge clk) disable iff (rst)
    step |=> (hist_q == $past(mq_q[0])));                                  // R8
  AST_GUARD_SIGN: assert property (@(posedge clk) disable iff (rst)
    (done || !busy) |-> (acc_q[AW-1] == acc_q[AW-2]));                     // R2

endmodule

// File: tb/booth_seq_mul_bench.sv
module booth_seq_mul_bench;

  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic           busy;
  logic           done;
  logic [W-1:0]   prod_hi;
  logic [W-1:0]   prod_lo;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  booth_seq_mul #(.WIDTH(W)) u_booth_seq_mul (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  always #10 clk = ~clk;

  // Behavioural reference, updated at each rising edge.
  logic              m_busy = 1'b0;
  logic              m_done = 1'b0;
  int                m_cnt  = 0;
  logic [2*W-1:0]    m_prod = '0;
  logic [2*W-1:0]    m_pend = '0;
  logic signed [2*W-1:0] full;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 1'b0; m_done = 1'b0; m_cnt = 0; m_prod = '0;
    end else begin
      m_done = 1'b0;
      if (!m_busy) begin
        if (start) begin
          full   = $signed(mcand) * $signed(mplier);
          m_pend = full;
          m_busy = 1'b1;
          m_cnt  = 0;
        end
      end else begin
        m_cnt = m_cnt + 1;
        if (m_cnt == W) begin
          m_busy = 1'b0;
          m_done = 1'b1;
          m_prod = m_pend;
        end
      end
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Every cycle, away from the rising edge.
  logic run_cmp = 1'b0;
  always @(negedge clk) begin
    if (run_cmp) begin
      check("R4", 64'(busy), 64'(m_busy));
      check("R3", 64'(done), 64'(m_done));
      if (!m_busy) check("R2/R6", 64'({prod_hi, prod_lo}), 64'(m_prod));
    end
  end

  task automatic mul(logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (W + 2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", 64'({busy, done, prod_hi, prod_lo}), 64'(0));
    run_cmp = 1'b1;

    // R9: 22 * -34 = -748
    mul(8'd22, 8'hDE);
    check("R9", 64'({prod_hi, prod_lo}), 64'(16'hFD14));

    // R7: extremes
    mul(8'h80, 8'h80);
    check("R7", 64'({prod_hi, prod_lo}), 64'(16'h4000));
    mul(8'h80, 8'hFF);
    check("R7", 64'({prod_hi, prod_lo}), 64'(16'h0080));
    mul(8'hFF, 8'h80);
    check("R7", 64'({prod_hi, prod_lo}), 64'(16'h0080));
    mul(8'h5B, 8'h00);
    check("R7", 64'({prod_hi, prod_lo}), 64'(0));
    mul(8'h00, 8'hA7);
    check("R7", 64'({prod_hi, prod_lo}), 64'(0));
    mul(8'h7F, 8'h7F);
    check("R7", 64'({prod_hi, prod_lo}), 64'(16'h3F01));

    // R8: alternating multipliers force an operation on every step
    mul(8'h80, 8'h55);
    check("R8", 64'({prod_hi, prod_lo}), 64'(16'hD580));
    mul(8'h80, 8'hAA);
    check("R8", 64'({prod_hi, prod_lo}), 64'(16'h2B00));
    mul(8'h13, 8'hFF);
    check("R8", 64'({prod_hi, prod_lo}), 64'(16'hFFED));

    // R5: start and operand changes while busy are ignored
    @(negedge clk);
    mcand = 8'd9; mplier = 8'hF9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < W - 2; k++) begin
      @(negedge clk);
      mcand = 8'(k * 37); mplier = 8'(k * 91); start = k[0];
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    check("R5", 64'({prod_hi, prod_lo}), 64'(16'hFFC1));

    // R6: start held high restarts on the cycle of done
    @(negedge clk);
    mcand = 8'hF3; mplier = 8'h0B; start = 1'b1;
    repeat (3 * (W + 1)) @(negedge clk);
    start = 1'b0;
    repeat (W + 2) @(negedge clk);
    check("R6", 64'({prod_hi, prod_lo}), 64'(16'hFF71));

    // R2: random operands
    for (int i = 0; i < 300; i++) mul(8'($urandom), 8'($urandom));

    run_cmp = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule